// File: doc/BRIEF.md
# SPI Master with Selectable Clock Polarity and Phase

This block is a full-duplex serial master that swaps one 8-bit word with a slave per transfer. During each transfer it shifts a byte out on `mosi` while it shifts a byte in from `miso` over the same sixteen clock edges, most significant bit first. A one-entry transmit buffer sits in front of the outgoing shift register and a one-entry receive buffer sits behind the incoming one. Software can therefore queue the next byte while the current one is on the wire, and can read the last received byte after the next transfer has started.

A transfer starts whenever `selEn` is high while the block is idle. If nothing is queued, the block shifts out the dummy value 0xFF. The serial clock half-period is programmable. Two mode inputs choose the idle level of the serial clock, which of its edges is active, and whether data is launched or captured on the active edge. Once a transfer has started it always runs to completion.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, and between transfers, `ssN` is 1, `mosi` is 1 and `sck` sits at the idle level set by `cpol`. After reset, `txEmpty` is 1, `rxValid` is 0 and `overrun` is 0.
- R2: Let H be `divSel`+1. `ssN` falls H system cycles before the first `sck` edge. Each transfer has exactly 16 `sck` edges spaced H cycles apart. `ssN` rises H cycles after the 16th edge.
- R3: Each transfer sends one byte on `mosi` and receives one byte from `miso`, both bit 7 first. The received byte appears on `rxData` when `ssN` rises.
- R4: With `cpol`=0, `sck` idles at 0 and its rising edges are active. With `cpol`=1, `sck` idles at 1 and its falling edges are active. The first edge of a transfer is always active.
- R5: With `cpha`=0, `mosi` holds 1 until the first active edge. Each bit is launched on an active edge, and `miso` is sampled on the following inactive edge.
- R6: With `cpha`=1, bit 7 is on `mosi` from the cycle `ssN` falls. Later bits change on inactive edges, and `miso` is sampled on active edges.
- R7: The byte written with `txWrite` is taken into the shift register in the cycle the transfer starts, which sets `txEmpty` to 1. A write clears `txEmpty` and replaces any byte still queued. A write in the start cycle is kept for the next transfer.
- R8: A transfer that starts with `txEmpty`=1 sends 0xFF.
- R9: `rxValid` rises together with `ssN` at the end of each transfer. It stays set until `rxRead` is pulsed.
- R10: If a transfer ends while `rxValid` is still set and `rxRead` is not pulsed in that cycle, `overrun` becomes 1. It stays 1 until `rxRead` is pulsed.
- R11: A transfer starts in the first cycle `selEn` is 1 while idle and always completes all 16 edges, even if `selEn` falls. With `selEn` held high, transfers follow back to back with `ssN` high for one cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divSel | input | DIV_W | Serial clock half-period minus one, in system cycles |
| cpol | input | 1 | Clock polarity: 0 idle low / rising active, 1 idle high / falling active |
| cpha | input | 1 | Clock phase: 0 launch on active edge, 1 capture on active edge |
| selEn | input | 1 | Request to select the slave and run transfers |
| txWrite | input | 1 | Write strobe for the transmit buffer |
| txData | input | DATA_W | Byte to queue for sending |
| miso | input | 1 | Serial data from the slave |
| rxRead | input | 1 | Acknowledges the receive buffer, clears `rxValid` and `overrun` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssN | output | 1 | Active-low slave select |
| rxData | output | DATA_W | Most recently received byte |
| rxValid | output | 1 | Receive buffer holds an unread byte |
| txEmpty | output | 1 | Transmit buffer has no byte queued |
| overrun | output | 1 | A received byte replaced an unread one |

## Verification
Transfers are run in all four polarity and phase combinations at half-periods of one, two and four cycles. Each one uses byte pairs with asymmetric bit patterns, so a reversed bit order, an off-by-one sample point or a wrong edge shows up as a wrong byte on one side of the swap. A transfer with no queued byte separates the dummy path from a stale buffer. Back-to-back transfers with a write during the first one separate the buffer from the shift register. Two transfers with no read in between, followed by a read, exercise setting and clearing the overrun flag.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  // Strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic load;     // take the queued byte (or dummy) into the shift register
    logic launch;   // present the next bit on the serial output
    logic capture;  // sample the serial input into the receive shifter
    logic commit;   // move the received word to the receive buffer
  } xferStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TRAIL = 2'd2
  } xferStateT;

endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             selEn,
  output logic             sck,
  output logic             ssN,
  output xferStrobeT       strobe
);

  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES + 1);
  localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(EDGES);

  xferStateT        state;
  logic [DIV_W-1:0] cnt;
  logic [EC_W-1:0]  edgeCnt;
  logic [EC_W-1:0]  edgeNum;
  logic             halfDone;
  logic             activeEdge;
  logic             lastEdge;

  // Edges are numbered from 1; odd numbers are the active ones
  assign halfDone   = (cnt >= divSel);
  assign edgeNum    = edgeCnt + 1'b1;
  assign activeEdge = edgeNum[0];
  assign lastEdge   = (edgeNum == LAST_EDGE);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (selEn) begin
          strobe.load   = 1'b1;
          strobe.launch = cpha;  // phase 1 pre-drives the first bit
        end
      end
      ST_SHIFT: begin
        if (halfDone) begin
          if (activeEdge) begin
            strobe.launch  = !cpha;
            strobe.capture = cpha;
          end else begin
            strobe.capture = !cpha;
            strobe.launch  = cpha && !lastEdge;
          end
        end
      end
      ST_TRAIL: begin
        strobe.commit = halfDone;
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      edgeCnt <= '0;
      sck     <= 1'b0;
      ssN     <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sck     <= cpol;
          cnt     <= '0;
          edgeCnt <= '0;
          if (selEn) begin
            state <= ST_SHIFT;
            ssN   <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (halfDone) begin
            cnt     <= '0;
            sck     <= ~sck;
            edgeCnt <= edgeNum;
            if (lastEdge) state <= ST_TRAIL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TRAIL: begin
          if (halfDone) begin
            cnt   <= '0;
            ssN   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SCK_HOLDS_MIDHALF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && !halfDone) |=> $stable(sck)); // R2
  AST_TRAIL_AFTER_ALL_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRAIL) |-> (edgeCnt == LAST_EDGE && !ssN)); // R2
  AST_SELECT_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |=> !ssN); // R11

endmodule

// File: rtl/spi_xfer_dp.sv
module spi_xfer_dp
  import spi_xfer_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] DUMMY  = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobeT        strobe,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  input  logic              rxRead,
  output logic              mosi,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txEmpty,
  output logic              overrun
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] txBuf;
  logic              txFull;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] nextWord;
  logic [DATA_W-1:0] shiftSrc;

  assign nextWord = txFull ? txBuf : DUMMY;
  assign shiftSrc = strobe.load ? nextWord : txShift;
  assign txEmpty  = !txFull;

  // Transmit buffer: a write wins over the load in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf  <= '0;
      txFull <= 1'b0;
    end else if (txWrite) begin
      txBuf  <= txData;
      txFull <= 1'b1;
    end else if (strobe.load) begin
      txFull <= 1'b0;
    end
  end

  // Outgoing shifter and serial output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      mosi    <= 1'b1;
    end else begin
      if (strobe.launch) begin
        mosi    <= shiftSrc[MSB];
        txShift <= {shiftSrc[MSB-1:0], 1'b0};
      end else if (strobe.load) begin
        mosi    <= 1'b1;
        txShift <= shiftSrc;
      end else if (strobe.commit) begin
        mosi    <= 1'b1;
      end
    end
  end

  // Incoming shifter and receive buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (strobe.capture) rxShift <= {rxShift[MSB-1:0], miso};
      if (strobe.commit) rxData <= rxShift;
      rxValid <= strobe.commit || (rxValid && !rxRead);
      overrun <= (strobe.commit && rxValid && !rxRead) || (overrun && !rxRead);
    end
  end

  AST_COMMIT_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> rxValid); // R9
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> ($past(rxValid) && $past(strobe.commit))); // R10
  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !txWrite) |=> txEmpty); // R7
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |=> !txEmpty); // R7
  AST_NO_SHIFT_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.commit && (strobe.launch || strobe.capture || strobe.load))); // R3

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter int                DIV_W  = 8,
  parameter logic [DATA_W-1:0] DUMMY  = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divSel,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              selEn,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              miso,
  input  logic              rxRead,
  output logic              sck,
  output logic              mosi,
  output logic              ssN,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              txEmpty,
  output logic              overrun
);

  xferStrobeT strobe;

  spi_xfer_ctrl #(
    .DATA_W(DATA_W),
    .DIV_W (DIV_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .divSel(divSel),
    .cpol  (cpol),
    .cpha  (cpha),
    .selEn (selEn),
    .sck   (sck),
    .ssN   (ssN),
    .strobe(strobe)
  );

  spi_xfer_dp #(
    .DATA_W(DATA_W),
    .DUMMY (DUMMY)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .txWrite(txWrite),
    .txData (txData),
    .miso   (miso),
    .rxRead (rxRead),
    .mosi   (mosi),
    .rxData (rxData),
    .rxValid(rxValid),
    .txEmpty(txEmpty),
    .overrun(overrun)
  );

endmodule

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divSel = 8'd0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       selEn = 1'b0;
  logic       txWrite = 1'b0;
  logic [7:0] txData = 8'd0;
  logic       miso = 1'b1;
  logic       rxRead = 1'b0;
  logic       sck, mosi, ssN, rxValid, txEmpty, overrun;
  logic [7:0] rxData;

  always #4 clk = ~clk;

  spi_xfer_master u_dut (
    .clk(clk), .rstN(rstN), .divSel(divSel), .cpol(cpol), .cpha(cpha),
    .selEn(selEn), .txWrite(txWrite), .txData(txData), .miso(miso),
    .rxRead(rxRead), .sck(sck), .mosi(mosi), .ssN(ssN), .rxData(rxData),
    .rxValid(rxValid), .txEmpty(txEmpty), .overrun(overrun)
  );

  integer nChecks = 0;
  integer nFail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  integer     mT = -1;        // cycles since transfer start, -1 when idle
  integer     mH = 1;         // half-period of the running transfer
  integer     mCommits = 0;
  logic       mCpol = 0, mCpha = 0;
  logic [7:0] mByte = 8'hFF, mSlave = 8'h00, slaveByte = 8'h00;
  logic       mTxFull = 0;
  logic [7:0] mTxBuf = 0;
  logic       mRxV = 0, mOv = 0;
  logic [7:0] mRxD = 0;
  logic       eSck = 0, eMosi = 1;
  logic [7:0] gotMosi = 0, lastMosi = 0, prevMosi = 0;

  function automatic logic bitAt(input logic [7:0] b, input logic ph, input integer k);
    integer idx;
    if (!ph && k == 0) return 1'b1;
    idx = ph ? k / 2 : (k - 1) / 2;
    if (idx > 7) idx = 7;
    return b[7 - idx];
  endfunction

  always @(posedge clk) begin
    integer k;
    logic commit;
    commit = 1'b0;
    if (!rstN) begin
      mT = -1; eSck = 0; eMosi = 1; mTxFull = 0; mRxV = 0; mOv = 0; mRxD = 0;
    end else begin
      if (mT < 0) begin
        eSck = cpol;
        if (selEn) begin
          mT = 0; mH = divSel + 1; mCpol = cpol; mCpha = cpha;
          mByte = mTxFull ? mTxBuf : 8'hFF;
          mTxFull = 0;
          mSlave = slaveByte;
          gotMosi = 0;
          eMosi = cpha ? mByte[7] : 1'b1;
        end
      end else begin
        mT = mT + 1;
        if (mT == 17 * mH) begin
          commit = 1'b1;
          mT = -1;
          eMosi = 1'b1;
          mCommits = mCommits + 1;
          prevMosi = lastMosi;
          lastMosi = gotMosi;
        end else begin
          k = mT / mH;
          if (k > 16) k = 16;
          eSck = mCpol ^ k[0];
          eMosi = bitAt(mByte, mCpha, k);
        end
      end
      mOv = (commit && mRxV && !rxRead) || (mOv && !rxRead);
      mRxV = commit || (mRxV && !rxRead);
      if (commit) mRxD = mSlave;
      if (txWrite) begin
        mTxFull = 1'b1;
        mTxBuf = txData;
      end
    end
  end

  // slave model drives miso, bench collects mosi at slave sample points
  always @(negedge clk) begin
    integer k, n;
    if (mT >= 0) begin
      k = mT / mH;
      if (k > 16) k = 16;
      miso <= bitAt(mSlave, mCpha, k);
      if ((mT + 1) % mH == 0) begin
        n = (mT + 1) / mH;
        if (n >= 1 && n <= 16 && ((mCpha && n[0]) || (!mCpha && !n[0])))
          gotMosi = {gotMosi[6:0], mosi};
      end
    end else begin
      miso <= 1'b1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4", "sck", sck, eSck);
      chk("R2", "ssN", ssN, (mT < 0));
      chk(mCpha ? "R6" : "R5", "mosi", mosi, eMosi);
      chk("R7", "txEmpty", txEmpty, !mTxFull);
      chk("R9", "rxValid", rxValid, mRxV);
      chk("R10", "overrun", overrun, mOv);
      if (mRxV) chk("R3", "rxData", rxData, mRxD);
    end
  end

  // watchdog
  integer cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  task automatic doXfer(input logic cp, input logic ph, input logic [7:0] dv,
                        input logic haveTx, input logic [7:0] txB,
                        input logic [7:0] slB, input logic doRead);
    integer c0;
    c0 = mCommits;
    @(negedge clk);
    cpol = cp; cpha = ph; divSel = dv; slaveByte = slB;
    if (haveTx) begin txWrite = 1; txData = txB; end
    @(negedge clk);
    txWrite = 0; selEn = 1;
    @(negedge clk);
    selEn = 0;  // R11: dropping the request must not cut the transfer
    while (mCommits == c0) @(negedge clk);
    if (haveTx) chk("R3", "bits sent", lastMosi, txB);
    else        chk("R8", "dummy sent", lastMosi, 8'hFF);
    chk("R11", "received after early drop", rxData, slB);
    if (doRead) begin
      rxRead = 1;
      @(negedge clk);
      rxRead = 0;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", "idle ssN", ssN, 1'b1);
    chk("R1", "idle mosi", mosi, 1'b1);
    chk("R1", "idle sck", sck, 1'b0);
    chk("R1", "idle txEmpty", txEmpty, 1'b1);
    chk("R1", "idle rxValid", rxValid, 1'b0);
    chk("R1", "idle overrun", overrun, 1'b0);

    // all four modes, several rates and patterns
    doXfer(0, 0, 8'd0, 1, 8'hA5, 8'h3C, 1);
    doXfer(0, 1, 8'd1, 1, 8'h81, 8'h7E, 1);
    doXfer(1, 0, 8'd3, 1, 8'h1F, 8'hC2, 1);
    doXfer(1, 1, 8'd0, 1, 8'hE4, 8'h09, 1);
    doXfer(1, 1, 8'd3, 1, 8'h96, 8'hF0, 1);
    doXfer(0, 0, 8'd1, 1, 8'h01, 8'h80, 1);
    @(negedge clk);
    chk("R1", "idle sck after cpol=0", sck, 1'b0);

    // dummy byte with nothing queued
    doXfer(1, 0, 8'd1, 0, 8'h00, 8'h5A, 1);
    chk("R1", "idle sck after cpol=1", sck, 1'b1);

    // overrun: two transfers without a read, then a read
    doXfer(0, 1, 8'd2, 1, 8'h11, 8'h22, 0);
    doXfer(0, 1, 8'd2, 1, 8'h33, 8'h44, 0);
    chk("R10", "overrun set", overrun, 1'b1);
    chk("R10", "newest kept", rxData, 8'h44);
    rxRead = 1;
    @(negedge clk);
    rxRead = 0;
    chk("R10", "overrun cleared", overrun, 1'b0);
    chk("R9", "valid cleared", rxValid, 1'b0);

    // back to back with a write during the first transfer
    begin
      integer c0;
      c0 = mCommits;
      cpol = 0; cpha = 0; divSel = 8'd1; slaveByte = 8'hB7;
      txWrite = 1; txData = 8'h6D;
      @(negedge clk);
      txWrite = 0; selEn = 1;
      while (mT < 0) @(negedge clk);
      chk("R7", "buffer taken at start", txEmpty, 1'b1);
      repeat (3) @(negedge clk);
      txWrite = 1; txData = 8'hC9; slaveByte = 8'h4E;
      @(negedge clk);
      txWrite = 0;
      chk("R7", "queued during transfer", txEmpty, 1'b0);
      while (mCommits == c0) @(negedge clk);
      @(negedge clk);
      chk("R11", "second transfer started", ssN, 1'b0);
      selEn = 0;
      while (mCommits == c0 + 1) @(negedge clk);
      chk("R11", "first of pair", prevMosi, 8'h6D);
      chk("R7", "second of pair", lastMosi, 8'hC9);
      chk("R10", "overrun from pair", overrun, 1'b1);
      rxRead = 1;
      @(negedge clk);
      rxRead = 0;
    end

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule